// File: doc/BRIEF.md
# Dual I/O Window Decoder

This block sits beside one card socket and decides, for each host I/O cycle, whether the host address falls into one of two programmable I/O windows. Each window is described by a 16-bit first address and a 16-bit last address, both inclusive, and has its own enable bit. Software programs the windows through a byte-wide index/data register port.

When a cycle hits, the block reports which window matched. It also reports three per-cycle attributes taken from that window's four-bit control nibble: the data width (8 or 16 bits), a zero-wait-state request and a timing-set select. A nibble may hand the width choice to the card's IOCS16 pin instead of the programmed width bit. The decode result is registered and appears one clock after the cycle strobe is sampled.

Top module: `io_win_decoder`

## Requirements
- R1: After reset both windows are disabled and all configuration registers read as zero, so the outputs show no hit, window 0, and width, zero-wait and timing-select all low.
- R2: With the cycle strobe high at a rising edge, an enabled window hits when first <= address <= last. Both bounds are inclusive. The result appears on the outputs after that edge and holds for one cycle.
- R3: When the cycle strobe is low at an edge, the next outputs show no hit, whatever the address.
- R4: A window whose enable bit is clear never hits, whatever its bounds.
- R5: When both windows hit, window 0 is reported (output window index 0). Window 1 is reported (index 1) only when it alone hits.
- R6: Window 0's first address sits at indices 0x08 (low byte) and 0x09 (high byte), and its last address at 0x0A and 0x0B. Window 1 uses 0x0C/0x0D for the first address and 0x0E/0x0F for the last address.
- R7: Index 0x06 holds the enables: bit 6 for window 0 and bit 7 for window 1. Its other bits are discarded.
- R8: Index 0x07 holds the control nibbles: bits 3:0 for window 0 and bits 7:4 for window 1. Within a nibble, bit 0 sets the width to 16 when bit 1 is clear, and the IOCS16 pin then has no effect.
- R9: When nibble bit 1 is set, the width output follows the IOCS16 pin sampled in the cycle, and nibble bit 0 is ignored.
- R10: On a hit, the zero-wait output equals nibble bit 2 and the timing-select output equals nibble bit 3 of the matching window. On a miss, the width, zero-wait and timing-select outputs are all low.
- R11: A write to any index other than 0x06 through 0x0F leaves every decode result unchanged.
- R12: A window whose first address is above its last address matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| host_addr | input | 16 | Host I/O address |
| host_valid | input | 1 | I/O cycle strobe |
| card_iocs16 | input | 1 | Card 16-bit cycle request pin |
| dec_hit | output | 1 | A window matched |
| dec_win | output | 1 | Index of the matching window |
| dec_wide | output | 1 | Cycle is 16 bits wide |
| dec_zws | output | 1 | Zero wait states requested |
| dec_tsel | output | 1 | Timing register set select |

## Verification
The bench probes the addresses one below the first address, the first address itself, the last address, and one above the last address. A design that treats the last address as exclusive loses the last address of each window, and an off-by-one on the first address either drops the first address or takes in the address below it. Overlapping windows with both enabled expose a design that gives window 1 priority. Flipping IOCS16 under both width modes catches a design that lets the pin leak into programmed widths, or that ignores the pin when it should follow it. Writes to unrelated indices, an enable write with only the low bits set, and an inverted window catch decoders that alias indices, take enables from the wrong bits, or wrap their compares.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
    localparam int IOW_ADDR_W  = 16;
    localparam int IOW_IDX_W   = 8;
    localparam int IOW_DATA_W  = 8;
    localparam int IOW_NUM_WIN = 2;
    localparam int IOW_NIB_W   = 4;

    localparam logic [IOW_IDX_W-1:0] IDX_ENABLE = 8'h06;
    localparam logic [IOW_IDX_W-1:0] IDX_CTRL   = 8'h07;
    localparam int                   IDX_WBASE  = 8;
    localparam int                   WIN_STRIDE = 4;
    localparam int                   ENA_BIT0   = 6;

    localparam int CB_WIDE  = 0;
    localparam int CB_PIN   = 1;
    localparam int CB_ZWS   = 2;
    localparam int CB_TSEL  = 3;

    typedef struct packed {
        logic [IOW_ADDR_W-1:0] first;
        logic [IOW_ADDR_W-1:0] last;
        logic                  en;
        logic [IOW_NIB_W-1:0]  ctl;
    } win_cfg_t;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM_WIN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [IOW_IDX_W-1:0]  cfg_idx,
    input  logic [IOW_DATA_W-1:0] cfg_wdata,
    output win_cfg_t              win_cfg [NUM_WIN]
);
    localparam int BYTES_PER_WIN = WIN_STRIDE;
    localparam int IDX_LIMIT     = IDX_WBASE + BYTES_PER_WIN * NUM_WIN;

    typedef struct packed {
        logic [NUM_WIN-1:0][BYTES_PER_WIN-1:0][IOW_DATA_W-1:0] bytes;
        logic [NUM_WIN-1:0]                                    en;
        logic [NUM_WIN-1:0][IOW_NIB_W-1:0]                     ctl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (cfg_idx == IDX_ENABLE) begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    st_d.en[w] = cfg_wdata[ENA_BIT0 + w];
                end
            end
            if (cfg_idx == IDX_CTRL) begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    st_d.ctl[w] = cfg_wdata[w*IOW_NIB_W +: IOW_NIB_W];
                end
            end
            for (int w = 0; w < NUM_WIN; w++) begin
                for (int b = 0; b < BYTES_PER_WIN; b++) begin
                    if (cfg_idx == IOW_IDX_W'(IDX_WBASE + BYTES_PER_WIN*w + b)) begin
                        st_d.bytes[w][b] = cfg_wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cfg
        assign win_cfg[w].first = {st_q.bytes[w][1], st_q.bytes[w][0]};
        assign win_cfg[w].last  = {st_q.bytes[w][3], st_q.bytes[w][2]};
        assign win_cfg[w].en    = st_q.en[w];
        assign win_cfg[w].ctl   = st_q.ctl[w];
    end

    logic idx_known;
    assign idx_known = (cfg_idx == IDX_ENABLE) || (cfg_idx == IDX_CTRL) ||
                       ((int'(cfg_idx) >= IDX_WBASE) && (int'(cfg_idx) < IDX_LIMIT));

    // R11: unrelated indices leave the stored configuration alone
    a_r11_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && idx_known) |=> $stable(st_q));

    // R1: configuration is cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (st_q == '0));
endmodule

// File: rtl/io_win_match.sv
module io_win_match
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM_WIN
) (
    input  logic [IOW_ADDR_W-1:0] addr,
    input  win_cfg_t              win_cfg [NUM_WIN],
    output logic [NUM_WIN-1:0]    hit_vec
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic ge_first, le_last;
        assign ge_first   = (addr >= win_cfg[w].first);
        assign le_last    = (addr <= win_cfg[w].last);
        assign hit_vec[w] = win_cfg[w].en & ge_first & le_last;
    end

    // R4: a disabled window reports no match
    always_comb begin
        for (int w = 0; w < NUM_WIN; w++) begin
            a_r4_disabled_quiet: assert (win_cfg[w].en || !hit_vec[w]);
        end
    end
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = IOW_NUM_WIN,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [IOW_IDX_W-1:0]  cfg_idx,
    input  logic [IOW_DATA_W-1:0] cfg_wdata,
    input  logic [IOW_ADDR_W-1:0] host_addr,
    input  logic                  host_valid,
    input  logic                  card_iocs16,
    output logic                  dec_hit,
    output logic [WIN_W-1:0]      dec_win,
    output logic                  dec_wide,
    output logic                  dec_zws,
    output logic                  dec_tsel
);
    win_cfg_t           win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;

    io_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .win_cfg   (win_cfg)
    );

    io_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr    (host_addr),
        .win_cfg (win_cfg),
        .hit_vec (hit_vec)
    );

    typedef struct packed {
        logic             hit;
        logic [WIN_W-1:0] win;
        logic             wide;
        logic             zws;
        logic             tsel;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        logic                 found;
        logic [IOW_NIB_W-1:0] nib;
        found = 1'b0;
        nib   = '0;
        out_d = '0;
        if (host_valid) begin
            // lowest index wins
            for (int w = NUM_WIN-1; w >= 0; w--) begin
                if (hit_vec[w]) begin
                    found     = 1'b1;
                    out_d.win = WIN_W'(w);
                    nib       = win_cfg[w].ctl;
                end
            end
        end
        if (found) begin
            out_d.hit  = 1'b1;
            out_d.wide = nib[CB_PIN] ? card_iocs16 : nib[CB_WIDE];
            out_d.zws  = nib[CB_ZWS];
            out_d.tsel = nib[CB_TSEL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_hit  = out_q.hit;
    assign dec_win  = out_q.win;
    assign dec_wide = out_q.wide;
    assign dec_zws  = out_q.zws;
    assign dec_tsel = out_q.tsel;

    // R3: no cycle strobe, no hit
    a_r3_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> !dec_hit);

    // R10: a miss leaves every attribute low
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (!dec_wide && !dec_zws && !dec_tsel && dec_win == '0));

    // R5: window 0 wins whenever it matches
    a_r5_low_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && hit_vec[0]) |=> (dec_hit && dec_win == '0));

    // R9: pin-decided width tracks the sampled pin
    a_r9_pin_width: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && hit_vec[0] && win_cfg[0].ctl[CB_PIN]) |=> (dec_wide == $past(card_iocs16)));

    // R2: a hit needs at least one enabled window in the sampled cycle
    a_r2_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && hit_vec == '0) |=> !dec_hit);
endmodule

// File: tb/io_win_decoder_bench.sv
module io_win_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic [15:0] host_addr;
    logic        host_valid;
    logic        card_iocs16;
    logic        dec_hit, dec_win, dec_wide, dec_zws, dec_tsel;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] shadow [16];

    always #4 clk = ~clk;

    io_win_decoder u_io_win_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .host_addr(host_addr), .host_valid(host_valid),
        .card_iocs16(card_iocs16), .dec_hit(dec_hit), .dec_win(dec_win),
        .dec_wide(dec_wide), .dec_zws(dec_zws), .dec_tsel(dec_tsel)
    );

    // expected {hit, win, wide, zws, tsel}
    function automatic logic [4:0] model(input logic [15:0] a, input logic v, input logic pin);
        logic [4:0] r;
        r = '0;
        if (v) begin
            for (int w = 1; w >= 0; w--) begin
                logic [15:0] f, l;
                logic [3:0]  n;
                f = {shadow[9 + 4*w], shadow[8 + 4*w]};
                l = {shadow[11 + 4*w], shadow[10 + 4*w]};
                n = shadow[7][4*w +: 4];
                if (shadow[6][6 + w] && a >= f && a <= l) begin
                    r = {1'b1, 1'(w), (n[1] ? pin : n[0]), n[2], n[3]};
                end
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got hit/win/wide/zws/tsel=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx >= 8'h06 && idx <= 8'h0F) shadow[idx[3:0]] = d;
    endtask

    task automatic set_win(input int w, input logic [15:0] f, input logic [15:0] l);
        wr(8'(8 + 4*w), f[7:0]);
        wr(8'(9 + 4*w), f[15:8]);
        wr(8'(10 + 4*w), l[7:0]);
        wr(8'(11 + 4*w), l[15:8]);
    endtask

    task automatic look(input string tag, input logic [15:0] a, input logic v, input logic pin);
        @(negedge clk);
        host_addr = a; host_valid = v; card_iocs16 = pin;
        @(negedge clk);
        host_valid = 1'b0;
        check(tag, {dec_hit, dec_win, dec_wide, dec_zws, dec_tsel}, model(a, v, pin));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4117));
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        host_addr = '0; host_valid = 1'b0; card_iocs16 = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {dec_hit, dec_win, dec_wide, dec_zws, dec_tsel}, 5'b0);
        rst_n = 1'b1;
        look("R1 nothing enabled after reset", 16'h0000, 1'b1, 1'b1);

        // R6 layout: w0 0x0300..0x031F, w1 0x0310..0x033F
        set_win(0, 16'h0300, 16'h031F);
        set_win(1, 16'h0310, 16'h033F);
        wr(8'h07, 8'hA5);                 // R8 w0 nibble 0x5, R9 w1 nibble 0xA
        wr(8'h06, 8'h80);                 // R7 only window 1
        look("R4 window 0 disabled", 16'h0305, 1'b1, 1'b0);
        look("R7 window 1 via bit 7", 16'h0315, 1'b1, 1'b1);
        wr(8'h06, 8'h3F);                 // R7 low bits enable nothing
        look("R7 low enable bits ignored", 16'h0315, 1'b1, 1'b1);
        wr(8'h06, 8'hC0);
        look("R5 overlap goes to window 0", 16'h0315, 1'b1, 1'b1);
        look("R2 first address inclusive", 16'h0300, 1'b1, 1'b0);
        look("R2 last address inclusive", 16'h031F, 1'b1, 1'b0);
        look("R2 above w0 hits w1", 16'h0320, 1'b1, 1'b0);
        look("R2 below first misses", 16'h02FF, 1'b1, 1'b1);
        look("R2 above last misses", 16'h0340, 1'b1, 1'b1);
        look("R3 strobe low", 16'h0305, 1'b0, 1'b1);
        look("R9 pin high widens", 16'h0330, 1'b1, 1'b1);
        look("R9 pin low narrows", 16'h0330, 1'b1, 1'b0);
        wr(8'h07, 8'hB4);                 // w1 bit0 set but pin decides; w0 narrow
        look("R9 width bit ignored", 16'h0330, 1'b1, 1'b0);
        look("R8 pin ignored w0", 16'h0305, 1'b1, 1'b1);
        look("R10 zws/tsel w0", 16'h0301, 1'b1, 1'b0);
        wr(8'h07, 8'hC9);
        look("R10 tsel w0 wide", 16'h0301, 1'b1, 1'b0);
        look("R10 zws/tsel w1", 16'h0333, 1'b1, 1'b0);
        // R11 foreign writes
        wr(8'h10, 8'hFF); wr(8'h05, 8'h00); wr(8'h00, 8'h00); wr(8'h18, 8'h00);
        look("R11 foreign writes w0", 16'h0300, 1'b1, 1'b0);
        look("R11 foreign writes w1", 16'h033F, 1'b1, 1'b1);
        // R12 inverted window
        set_win(1, 16'h5000, 16'h4FFF);
        look("R12 inverted at first", 16'h5000, 1'b1, 1'b1);
        look("R12 inverted at last", 16'h4FFF, 1'b1, 1'b1);

        for (int k = 0; k < 60; k++) begin
            logic [15:0] f0, f1;
            f0 = 16'($urandom);
            f1 = f0 + 16'($urandom_range(0, 64)) - 16'd32;
            set_win(0, f0, f0 + 16'($urandom_range(0, 48)));
            set_win(1, f1, f1 + 16'($urandom_range(0, 48)));
            wr(8'h07, 8'($urandom));
            wr(8'h06, 8'($urandom));
            for (int j = 0; j < 12; j++) begin
                logic [15:0] a;
                int sel;
                sel = int'($urandom_range(0, 5));
                case (sel)
                    0: a = {shadow[9], shadow[8]} - 16'd1;
                    1: a = {shadow[9], shadow[8]};
                    2: a = {shadow[11], shadow[10]};
                    3: a = {shadow[15], shadow[14]} + 16'd1;
                    4: a = {shadow[13], shadow[12]};
                    default: a = f0 + 16'($urandom_range(0, 80)) - 16'd16;
                endcase
                look("R2 R5 R9 R10 random", a, 1'($urandom_range(0, 7) != 0), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule